// File: doc/BRIEF.md
# Clock-Style Victim Frame Selector

This block keeps two flags for every page frame of a memory: a "recently used" flag and a "modified" flag. Every fetch, load or store that touches a frame reports the frame number on the access port. The block raises the used flag of that frame, and a store also raises its modified flag. When the operating software needs a frame to evict, it pulses a request. The block then sweeps a persistent hand around the frame table, one frame per clock. It stops at the first frame whose used flag is low and reports that frame's number together with its modified flag.

Every frame the hand passes over loses its used flag. A frame therefore survives one sweep after its last use and is picked on the next sweep if nothing touches it again. A per-request option makes the sweep prefer frames that are both unused and unmodified, which avoids a write-back to backing store. If one whole turn of the hand finds no such frame, the sweep carries on and takes the first unused frame. After a pick, the hand stays on the frame after the victim, so the next sweep starts there.

Top module: `nru_victim_select`

## Requirements
- R1: After synchronous reset, every used and modified flag is 0, the hand points at frame 0, and busy, done, victim_idx and victim_dirty are all 0.
- R2: An access with acc_valid high sets the used flag of frame acc_frame at the next edge. When acc_write is also 1, the access sets that frame's modified flag too. A modified flag is never cleared except by reset, and it is reported on victim_dirty when that frame is picked.
- R3: In normal mode, a sweep examines one frame per clock. It starts at the hand and goes in ascending order, wrapping from frame NUM_FRAMES-1 to frame 0. The first frame with a clear used flag is the victim.
- R4: Every frame the sweep examines and passes over has its used flag cleared, so a later sweep can pick it if it is not accessed again.
- R5: A request accepted at a clock edge raises busy from that edge on. If the sweep examines k frames, done is high for exactly one cycle after the k-th following edge, and busy drops at that same edge. victim_idx and victim_dirty change only when done rises, and they hold their values between picks.
- R6: When req_clean_pref is 1 at acceptance, the victim is the first frame, within one turn of NUM_FRAMES examinations, whose used flag and modified flag are both 0.
- R7: In clean-preferred mode, if NUM_FRAMES examinations find no such frame, the sweep continues in normal mode and picks the first frame with a clear used flag.
- R8: After a pick the hand rests on victim_idx+1, modulo NUM_FRAMES, so back-to-back requests on unused frames return consecutive frames.
- R9: An access in the same cycle that the sweep examines its target frame sets that frame's used flag, and that frame is not picked in that cycle.
- R10: req_valid is ignored while busy is high. No second sweep and no extra done pulse result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A frame is being accessed this cycle |
| acc_frame | input | IDX_W | Number of the accessed frame |
| acc_write | input | 1 | The access is a store |
| req_valid | input | 1 | Request a victim (accepted only while idle) |
| req_clean_pref | input | 1 | Prefer unused and unmodified frames for this request |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse: victim_idx and victim_dirty are new |
| victim_idx | output | IDX_W | Number of the chosen frame |
| victim_dirty | output | 1 | Modified flag of the chosen frame |

## Verification
A wrong flag or a displaced hand does not show at the ports until the next request. There it changes the victim number or the latency of done, often by several cycles. A used flag that failed to clear only shows up one full turn later. The bench therefore runs a behavioural model alongside the design and compares busy, done and both victim outputs on every cycle. This catches a divergence at the first pick that depends on the bad state. Directed sweeps pin the exact latency and victim for wraparound, clearing, clean preference, fallback and a same-cycle access.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/nru_frame_flags.sv
module nru_frame_flags #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic                  acc_write,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NUM_FRAMES-1:0] used_vec,
  output logic [NUM_FRAMES-1:0] mod_vec
);
  logic [NUM_FRAMES-1:0] used_q;
  logic [NUM_FRAMES-1:0] mod_q;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic hit_acc;
    logic hit_clr;
    assign hit_acc = acc_valid && (acc_frame == IDX_W'(g));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        used_q[g] <= 1'b0;
        mod_q[g]  <= 1'b0;
      end else begin
        // an access in the same cycle as a sweep clear wins
        if (hit_acc)      used_q[g] <= 1'b1;
        else if (hit_clr) used_q[g] <= 1'b0;
        if (hit_acc && acc_write) mod_q[g] <= 1'b1;
      end
    end
  end

  assign used_vec = used_q;
  assign mod_vec  = mod_q;

  AST_ACCESS_MARKS_USED: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> used_q[$past(acc_frame)]) else $error("access did not set used flag"); // R2

  AST_STORE_MARKS_MOD: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |=> mod_q[$past(acc_frame)]) else $error("store did not set modified flag"); // R2

  AST_MOD_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((mod_q & $past(mod_q)) == $past(mod_q))) else $error("modified flag dropped"); // R2
endmodule

// File: rtl/nru_sweep.sv
module nru_sweep
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_clean_pref,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic [NUM_FRAMES-1:0] used_vec,
  input  logic [NUM_FRAMES-1:0] mod_vec,
  output logic                  clr_en,
  output logic [IDX_W-1:0]      clr_idx,
  output logic                  busy,
  output logic                  done,
  output logic [IDX_W-1:0]      victim_idx,
  output logic                  victim_dirty
);
  localparam int               CNT_W    = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);
  localparam logic [CNT_W-1:0] FULL_REV = CNT_W'(NUM_FRAMES);

  sweep_state_e     state_q;
  logic [IDX_W-1:0] hand_q;
  logic [CNT_W-1:0] seen_q;
  logic             pref_q;
  logic             done_q;
  logic [IDX_W-1:0] vidx_q;
  logic             vdirty_q;

  logic             touched;
  logic             eff_used;
  logic             clean_phase;
  logic             pick;
  logic [IDX_W-1:0] hand_nxt;

  always_comb begin
    touched     = acc_valid && (acc_frame == hand_q);
    eff_used    = used_vec[hand_q] | touched;
    clean_phase = pref_q && (seen_q < FULL_REV);
    pick        = !eff_used && (!clean_phase || !mod_vec[hand_q]);
    hand_nxt    = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
  end

  assign clr_en  = (state_q == SWEEP_RUN);
  assign clr_idx = hand_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SWEEP_IDLE;
      hand_q   <= '0;
      seen_q   <= '0;
      pref_q   <= 1'b0;
      done_q   <= 1'b0;
      vidx_q   <= '0;
      vdirty_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SWEEP_IDLE: begin
          if (req_valid) begin
            state_q <= SWEEP_RUN;
            seen_q  <= '0;
            pref_q  <= req_clean_pref;
          end
        end
        SWEEP_RUN: begin
          hand_q <= hand_nxt;
          if (seen_q != FULL_REV) seen_q <= seen_q + 1'b1;
          if (pick) begin
            state_q  <= SWEEP_IDLE;
            done_q   <= 1'b1;
            vidx_q   <= hand_q;
            vdirty_q <= mod_vec[hand_q];
          end
        end
        default: state_q <= SWEEP_IDLE;
      endcase
    end
  end

  assign busy         = (state_q == SWEEP_RUN);
  assign done         = done_q;
  assign victim_idx   = vidx_q;
  assign victim_dirty = vdirty_q;

  AST_HAND_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (hand_q == (($past(hand_q) == LAST_IDX) ? '0 : $past(hand_q) + 1'b1)))
    else $error("hand skipped a frame"); // R3

  AST_HAND_AFTER_PICK: assert property (@(posedge clk) disable iff (rst)
    done |-> (hand_q == ((victim_idx == LAST_IDX) ? '0 : victim_idx + 1'b1)))
    else $error("hand not parked after victim"); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R5

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)) else $error("sweep without request"); // R10

  AST_TOUCHED_SPARED: assert property (@(posedge clk) disable iff (rst)
    done |-> !($past(acc_valid) && ($past(acc_frame) == victim_idx)))
    else $error("frame accessed in its own examination was picked"); // R9

  AST_CLEAN_PICK: assert property (@(posedge clk) disable iff (rst)
    (done && $past(pref_q) && ($past(seen_q) < FULL_REV)) |-> !victim_dirty)
    else $error("clean-preferred pick was modified"); // R6
endmodule

// File: rtl/nru_victim_select.sv
module nru_victim_select #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             acc_write,
  input  logic             req_valid,
  input  logic             req_clean_pref,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_dirty
);
  logic [NUM_FRAMES-1:0] used_vec;
  logic [NUM_FRAMES-1:0] mod_vec;
  logic                  clr_en;
  logic [IDX_W-1:0]      clr_idx;

  nru_frame_flags #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .acc_write (acc_write),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .used_vec  (used_vec),
    .mod_vec   (mod_vec)
  );

  nru_sweep #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_sweep (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_clean_pref (req_clean_pref),
    .acc_valid      (acc_valid),
    .acc_frame      (acc_frame),
    .used_vec       (used_vec),
    .mod_vec        (mod_vec),
    .clr_en         (clr_en),
    .clr_idx        (clr_idx),
    .busy           (busy),
    .done           (done),
    .victim_idx     (victim_idx),
    .victim_dirty   (victim_dirty)
  );
endmodule

// File: tb/tb_nru_victim_select.sv
module tb_nru_victim_select;
  localparam int NF = 8;
  localparam int IW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic          acc_write = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_clean_pref = 1'b0;
  logic          busy, done, victim_dirty;
  logic [IW-1:0] victim_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nru_victim_select #(.NUM_FRAMES(NF)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_write(acc_write), .req_valid(req_valid), .req_clean_pref(req_clean_pref),
    .busy(busy), .done(done), .victim_idx(victim_idx), .victim_dirty(victim_dirty)
  );

  // behavioural reference model
  bit m_used [NF];
  bit m_mod  [NF];
  int m_hand, m_seen;
  bit m_busy, m_pref, m_done, m_vdirty, m_lastpref, started;
  int m_vidx;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < NF; i++) begin m_used[i] = 0; m_mod[i] = 0; end
      m_hand = 0; m_seen = 0; m_busy = 0; m_pref = 0;
      m_done = 0; m_vidx = 0; m_vdirty = 0; m_lastpref = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        int p;
        bit hit, ok, eff;
        p   = m_hand;
        hit = acc_valid && (int'(acc_frame) == p);
        eff = m_used[p] || hit;
        ok  = !eff && !(m_pref && m_seen < NF && m_mod[p]);
        if (ok) begin
          m_done = 1; m_vidx = p; m_vdirty = m_mod[p]; m_busy = 0; m_lastpref = m_pref;
        end
        m_used[p] = 0;
        m_hand = (p + 1) % NF;
        m_seen++;
      end else if (req_valid) begin
        m_busy = 1; m_seen = 0; m_pref = req_clean_pref;
      end
      if (acc_valid) begin
        m_used[acc_frame] = 1;
        if (acc_write) m_mod[acc_frame] = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R5 busy vs model", int'(busy), int'(m_busy));
      chk("R5 done vs model", int'(done), int'(m_done));
      chk(m_lastpref ? "R6 victim_idx vs model" : "R3 victim_idx vs model", int'(victim_idx), m_vidx);
      chk("R2 victim_dirty vs model", int'(victim_dirty), int'(m_vdirty));
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic touch(int f, bit w);
    acc_valid = 1'b1; acc_frame = IW'(f); acc_write = w;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic request(bit pref, bit hit_en, int hit_f, output int lat, output int idx, output int dty);
    req_valid = 1'b1; req_clean_pref = pref;
    @(posedge clk); #1;
    req_valid = 1'b0; req_clean_pref = 1'b0;
    if (hit_en) begin acc_valid = 1'b1; acc_frame = IW'(hit_f); acc_write = 1'b0; end
    lat = 0;
    do begin
      @(posedge clk); #1;
      acc_valid = 1'b0;
      lat++;
    end while (!done && lat < 64);
    idx = int'(victim_idx);
    dty = int'(victim_dirty);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lat, idx, dty;
    do_reset();
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 victim_idx", int'(victim_idx), 0);
    chk("R1 victim_dirty", int'(victim_dirty), 0);

    // section A: plain sweeps
    request(0, 0, 0, lat, idx, dty);
    chk("R3 first victim", idx, 0); chk("R5 latency 1", lat, 1); chk("R2 clean frame", dty, 0);
    touch(1, 0); touch(2, 1);
    request(0, 0, 0, lat, idx, dty);
    chk("R2 used frames skipped", idx, 3); chk("R5 latency 3", lat, 3);
    touch(4, 0); touch(5, 0); touch(6, 0); touch(7, 0);
    request(0, 0, 0, lat, idx, dty);
    chk("R3 wrap to frame 0", idx, 0); chk("R5 latency 5", lat, 5);
    request(0, 0, 0, lat, idx, dty);
    chk("R4 cleared frame picked", idx, 1); chk("R8 next frame latency", lat, 1);
    request(0, 0, 0, lat, idx, dty);
    chk("R8 consecutive victim", idx, 2); chk("R2 modified reported", dty, 1);

    // section B: clean preference
    do_reset();
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 victim_idx after reset", int'(victim_idx), 0);
    touch(0, 1); touch(1, 1);
    request(0, 0, 0, lat, idx, dty);
    chk("R4 used frames passed", idx, 2);
    for (int k = 3; k < NF; k++) begin
      request(0, 0, 0, lat, idx, dty);
      chk("R8 stepping victim", idx, k);
    end
    request(1, 0, 0, lat, idx, dty);
    chk("R6 skip modified", idx, 2); chk("R6 latency", lat, 3); chk("R6 clean flag", dty, 0);

    // section C: full turn then fallback
    do_reset();
    for (int k = 0; k < NF; k++) touch(k, 1);
    request(0, 0, 0, lat, idx, dty);
    chk("R4 full turn victim", idx, 0); chk("R4 full turn latency", lat, NF + 1);
    chk("R2 all modified", dty, 1);
    request(1, 0, 0, lat, idx, dty);
    chk("R7 fallback victim", idx, 1); chk("R7 fallback latency", lat, NF + 1);
    chk("R7 fallback modified", dty, 1);

    // section D: access in the examination cycle
    do_reset();
    request(0, 1, 0, lat, idx, dty);
    chk("R9 touched frame spared", idx, 1); chk("R9 latency", lat, 2);

    // section E: request while busy
    touch(2, 0); touch(3, 0); touch(4, 0);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_clean_pref = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; req_clean_pref = 1'b0;
    lat = 2;
    while (!done && lat < 64) begin @(posedge clk); #1; lat++; end
    chk("R10 victim", int'(victim_idx), 5); chk("R10 latency", lat, 4);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 no second sweep busy", int'(busy), 0);
      chk("R10 no extra done", int'(done), 0);
    end

    // random phase, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      acc_valid = ($urandom % 3) == 0;
      acc_frame = IW'($urandom % NF);
      acc_write = ($urandom % 4) == 0;
      req_valid = busy ? (($urandom % 8) == 0) : (($urandom % 4) == 0);
      req_clean_pref = $urandom % 2;
      if (c == 2000) rst = 1'b1;
      if (c == 2002) rst = 1'b0;
      @(posedge clk); #1;
    end
    acc_valid = 1'b0; req_valid = 1'b0; rst = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    finish_run();
  end
endmodule